// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Pointer

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that fronts a 64-byte register space. It watches the bus for START and STOP conditions and answers the fixed 7-bit device address 68h. On the bus, the address byte is D0h for a write and D1h for a read. In a write transfer, the first byte after the address loads the word pointer. Every later byte is stored at the pointer, and the pointer then advances. In a read transfer, bytes are shifted out MSB first from the pointer, and the pointer advances after each byte. A master usually sets the pointer with a short write and then reads from it after a repeated START.

Both bus lines pass through multi-flop synchronisers into a fast system clock. The slave changes its data-line drive only after it sees a synchronised clock falling edge. The register space sits behind a simple synchronous port that has one-cycle read latency. A power-fail input aborts any transfer, returns the pointer to zero and makes the slave deaf to the bus for as long as the input is high.

Top module: `twire_reg_slave`

## Requirements
- R1: After reset the slave releases the data line (`sdaPullLow` = 0) and issues no register-port strobes.
- R2: An address byte of D0h (write) or D1h (read) is acknowledged. The slave pulls the data line low for the whole high phase of the ninth clock.
- R3: Any other address byte gets no acknowledge. The slave then leaves the data line released and writes nothing until the next START.
- R4: In a write, the first byte after D0h loads the pointer from its low 6 bits. Each later complete byte is acknowledged, written at the pointer with a single-cycle `memWrEn` pulse, and the pointer then advances by one. A byte cut short by STOP or START is not written.
- R5: In a read, each byte is driven MSB first from the pointer. The pointer advances after each byte, and each read fetch is a single-cycle `memRdEn` pulse.
- R6: The pointer wraps from 63 to 0 on both writes and reads.
- R7: A repeated START carrying D1h after a write reads from the pointer that the write left.
- R8: When the master does not acknowledge a read byte, the read ends. The slave keeps the data line released until the next START or STOP.
- R9: A transfer may carry any number of bytes between START and STOP, and STOP returns the slave to idle.
- R10: While `powerFail` is high, the slave drives nothing, strobes nothing and acknowledges nothing. The transfer in progress is dropped, and the pointer is 0 once the input falls.
- R11: The data-line drive changes only while the bus clock is low, except for the release forced by power-fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullLow | output | 1 | 1 = pull the data line low, 0 = release it |
| powerFail | input | 1 | Supply out of tolerance; aborts and mutes the slave |
| memAddr | output | 6 | Register-space address for the current strobe |
| memWrEn | output | 1 | Single-cycle write strobe |
| memWrData | output | 8 | Write data |
| memRdEn | output | 1 | Single-cycle read strobe; data is expected on the next cycle |
| memRdData | input | 8 | Read data, valid the cycle after `memRdEn` |

## Verification
A wrong FSM state or bit count shows at the ports within one bus bit. The slave then drives the data line during a data bit, acknowledges in the wrong slot or misses an acknowledge, and the per-clock comparison of the data-line drive against the bench's model catches it during the high phase of that clock. A wrong pointer does not show until later: it appears as misplaced data in the register space or as a mismatching byte on a later read. Reads with a repeated START and a final comparison of the whole register space expose it within the same test.

// File: rtl/twire_pkg.sv
package twire_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_ADDR,
    ST_RX_WORD,
    ST_RX_DATA,
    ST_ACK,
    ST_TX_DATA,
    ST_TX_ACK,
    ST_IGNORE
  } slvState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic clrBits;    // restart the bit counter
    logic loadPtr;    // pointer <= received byte
    logic wrByte;     // write received byte at pointer, advance
    logic fetchCur;   // read at pointer
    logic fetchNext;  // advance pointer, read at new value
    logic driveAck;   // pull data line low for an acknowledge
    logic driveBit;   // put next transmit bit on the line
    logic relSda;     // release the data line
  } dpStrobe_t;

endpackage

// File: rtl/twire_datapath.sv
module twire_datapath
  import twire_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         stb,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaPullLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [BYTE_W-1:0] memWrData,
  output logic              memRdEn,
  input  logic [BYTE_W-1:0] memRdData
);

  localparam int CNT_W = $clog2(BYTE_W + 2);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclS, sdaS, sclPrev, sdaPrev;
  logic                   sclRise;
  logic [CNT_W-1:0]       bitCnt;
  logic [BYTE_W-1:0]      rxShift, txShift;
  logic [ADDR_W-1:0]      ptr;
  logic                   rdLatch;

  // synchronisers, idle-high reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      if (sclRise) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (powerFail || stb.clrBits) bitCnt <= '0;
      else if (sclRise)             bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign rxByte   = rxShift;

  // pointer and register-space port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      memAddr   <= '0;
      memWrEn   <= 1'b0;
      memWrData <= '0;
      memRdEn   <= 1'b0;
      rdLatch   <= 1'b0;
    end else begin
      memWrEn <= 1'b0;
      memRdEn <= 1'b0;
      rdLatch <= memRdEn & ~powerFail;
      if (powerFail) begin
        ptr <= '0;
      end else begin
        if (stb.loadPtr) ptr <= rxShift[ADDR_W-1:0];
        if (stb.wrByte) begin
          memWrEn   <= 1'b1;
          memWrData <= rxShift;
          memAddr   <= ptr;
          ptr       <= ptr + ADDR_W'(1);
        end
        if (stb.fetchCur) begin
          memRdEn <= 1'b1;
          memAddr <= ptr;
        end
        if (stb.fetchNext) begin
          memRdEn <= 1'b1;
          memAddr <= ptr + ADDR_W'(1);
          ptr     <= ptr + ADDR_W'(1);
        end
      end
    end
  end

  // transmit shifter and line drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift    <= '1;
      sdaPullLow <= 1'b0;
    end else begin
      if (rdLatch)           txShift <= memRdData;
      else if (stb.driveBit) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (powerFail || stb.relSda) sdaPullLow <= 1'b0;
      else if (stb.driveAck)       sdaPullLow <= 1'b1;
      else if (stb.driveBit)       sdaPullLow <= ~txShift[BYTE_W-1];
    end
  end

endmodule

// File: rtl/twire_ctrl.sv
module twire_ctrl
  import twire_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         stb
);

  localparam logic [BYTE_W-1:0] WR_CODE = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] RD_CODE = {DEV_ADDR, 1'b1};

  slvState_t state, stateN, ackNext, ackNextN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackNext <= ST_IDLE;
    end else begin
      state   <= stateN;
      ackNext <= ackNextN;
    end
  end

  always_comb begin
    stb      = '0;
    stateN   = state;
    ackNextN = ackNext;
    if (powerFail) begin
      stateN = ST_IDLE;
    end else if (stopDet) begin
      stateN      = ST_IDLE;
      stb.relSda  = 1'b1;
      stb.clrBits = 1'b1;
    end else if (startDet) begin
      stateN      = ST_RX_ADDR;
      stb.relSda  = 1'b1;
      stb.clrBits = 1'b1;
    end else if (sclFall) begin
      unique case (state)
        ST_RX_ADDR: if (byteDone) begin
          if (rxByte == WR_CODE) begin
            stb.driveAck = 1'b1;
            ackNextN     = ST_RX_WORD;
            stateN       = ST_ACK;
          end else if (rxByte == RD_CODE) begin
            stb.driveAck = 1'b1;
            stb.fetchCur = 1'b1;
            ackNextN     = ST_TX_DATA;
            stateN       = ST_ACK;
          end else begin
            stateN = ST_IGNORE;
          end
        end
        ST_RX_WORD: if (byteDone) begin
          stb.loadPtr  = 1'b1;
          stb.driveAck = 1'b1;
          ackNextN     = ST_RX_DATA;
          stateN       = ST_ACK;
        end
        ST_RX_DATA: if (byteDone) begin
          stb.wrByte   = 1'b1;
          stb.driveAck = 1'b1;
          ackNextN     = ST_RX_DATA;
          stateN       = ST_ACK;
        end
        ST_ACK: begin
          stb.clrBits = 1'b1;
          if (ackNext == ST_TX_DATA) stb.driveBit = 1'b1;
          else                       stb.relSda   = 1'b1;
          stateN = ackNext;
        end
        ST_TX_DATA: begin
          if (byteDone) begin
            stb.relSda    = 1'b1;
            stb.fetchNext = 1'b1;
            stateN        = ST_TX_ACK;
          end else begin
            stb.driveBit = 1'b1;
          end
        end
        ST_TX_ACK: begin
          stb.clrBits = 1'b1;
          if (!rxByte[0]) begin
            stb.driveBit = 1'b1;
            stateN       = ST_TX_DATA;
          end else begin
            stateN = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twire_reg_slave.sv
module twire_reg_slave
  import twire_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         ADDR_W      = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic              powerFail,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic              memRdEn,
  input  logic [7:0]        memRdData
);

  dpStrobe_t         stb;
  logic              sclFall, startDet, stopDet, byteDone;
  logic [BYTE_W-1:0] rxByte;

  twire_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .rxByte(rxByte), .stb(stb)
  );

  twire_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .rxByte(rxByte), .sdaPullLow(sdaPullLow),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdEn(memRdEn), .memRdData(memRdData)
  );

endmodule

// File: rtl/twire_reg_slave_chk.sv
module twire_reg_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaPullLow,
  input logic powerFail,
  input logic memWrEn,
  input logic memRdEn
);

  // R10: muted while the supply is out of tolerance
  p_pf_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> (!sdaPullLow && !memWrEn && !memRdEn));

  // R11: drive moves only with the bus clock low
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaPullLow) && !$past(powerFail)) |-> !sclIn);

  // R4: one write strobe per byte
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R5: one read strobe per fetch
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R1: never both strobes at once
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));

endmodule

bind twire_reg_slave twire_reg_slave_chk chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .powerFail(powerFail), .memWrEn(memWrEn), .memRdEn(memRdEn)
);

// File: tb/twire_reg_slave_test.sv
`timescale 1ns/1ps
module twire_reg_slave_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclLine = 1'b1;
  logic       sdaM = 1'b1;
  logic       powerFail = 1'b0;
  logic       sdaPullLow;
  logic [5:0] memAddr;
  logic       memWrEn, memRdEn;
  logic [7:0] memWrData, memRdData;
  wire        sdaBus = sdaM & ~sdaPullLow;

  int checks = 0;
  int errors = 0;
  int expDrive = -1;
  string expReq = "";
  bit done = 0;

  logic [7:0] benchMem [64];
  int refMem [64];
  int refPtr = 0;
  int refWrites = 0;
  int seenWrites = 0;

  always #10 clk = ~clk;

  twire_reg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .powerFail(powerFail),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdEn(memRdEn), .memRdData(memRdData)
  );

  // register space seen by the slave
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) benchMem[i] <= 8'(i * 5 + 1);
      memRdData <= 8'h00;
    end else begin
      if (memWrEn) begin
        benchMem[memAddr] <= memWrData;
        seenWrites <= seenWrites + 1;
      end
      if (memRdEn) memRdData <= benchMem[memAddr];
    end
  end

  // per-clock comparison of the line drive against the model
  always @(negedge clk) begin
    if (rstN && expDrive >= 0) begin
      checks++;
      if (sdaPullLow !== (expDrive == 1)) begin
        errors++;
        $display("FAIL %s: sdaPullLow=%0b expected %0b at %0t", expReq,
                 sdaPullLow, expDrive == 1, $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    expDrive = -1;
    sdaM = 1'b1; tick(10);
    sclLine = 1'b1; tick(10);
    sdaM = 1'b0; tick(10);
    sclLine = 1'b0; tick(5);
  endtask

  task automatic busStop();
    expDrive = -1;
    sdaM = 1'b0; tick(10);
    sclLine = 1'b1; tick(10);
    sdaM = 1'b1; tick(10);
  endtask

  task automatic clockBit(bit b, int exp, string req, output bit smp);
    sdaM = b; tick(10);
    expReq = req; expDrive = exp;
    sclLine = 1'b1; tick(10);
    smp = sdaBus; tick(10);
    expDrive = -1;
    sclLine = 1'b0; tick(10);
  endtask

  task automatic sendByte(logic [7:0] b, bit expAck, string req);
    bit smp;
    for (int i = 7; i >= 0; i--) clockBit(b[i], 0, req, smp);
    clockBit(1'b1, expAck ? 1 : 0, req, smp);
    check(smp == !expAck, req, smp, !expAck);
  endtask

  task automatic readByte(logic [7:0] exp, bit mAck, string req);
    bit smp;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, exp[i] ? 0 : 1, req, smp);
      got[i] = smp;
    end
    clockBit(!mAck, 0, req, smp);
    check(got == exp, req, got, exp);
  endtask

  // model-side helpers
  task automatic writeRef(int b);
    refMem[refPtr] = b;
    refPtr = (refPtr + 1) % 64;
    refWrites++;
  endtask

  task automatic setPointer(int p, string req);
    busStart();
    sendByte(8'hD0, 1, "R2");
    sendByte(8'(p), 1, req);
    refPtr = p % 64;
  endtask

  task automatic readBurst(int n, string req);
    busStart();
    sendByte(8'hD1, 1, "R7");
    for (int i = 0; i < n; i++) begin
      readByte(8'(refMem[refPtr]), i != n - 1, req);
      refPtr = (refPtr + 1) % 64;
    end
  endtask

  initial begin
    bit smp;
    for (int i = 0; i < 64; i++) refMem[i] = (i * 5 + 1) % 256;
    tick(5);
    rstN = 1'b1;
    tick(3);
    // R1: reset state
    check(sdaPullLow == 1'b0, "R1", sdaPullLow, 0);
    check(memWrEn == 1'b0 && memRdEn == 1'b0, "R1", {memWrEn, memRdEn}, 0);

    // R2, R4: short write at 5
    setPointer(5, "R4");
    sendByte(8'h11, 1, "R4"); writeRef(8'h11);
    sendByte(8'h22, 1, "R4"); writeRef(8'h22);
    sendByte(8'h33, 1, "R4"); writeRef(8'h33);
    busStop();

    // R7, R5, R8: repeated START read from 5, NACK on last
    setPointer(5, "R7");
    readBurst(3, "R5");
    clockBit(1'b1, 0, "R8", smp);
    check(smp == 1'b1, "R8", smp, 1);
    busStop();

    // R3: foreign address, then a byte that must be neither acked nor written
    busStart();
    sendByte(8'hA0, 0, "R3");
    sendByte(8'h00, 0, "R3");
    busStop();

    // R9, R6: long write wrapping through the whole space
    setPointer(0, "R9");
    for (int i = 0; i < 70; i++) begin
      sendByte(8'(i * 7 + 3), 1, "R9");
      writeRef((i * 7 + 3) % 256);
    end
    busStop();
    check(refPtr == 6, "R9", refPtr, 6);

    // R6: read across 63 -> 0
    setPointer(61, "R6");
    readBurst(5, "R6");
    busStop();

    // R10: abort mid-byte, ignore bus, pointer reset
    setPointer(20, "R10");
    sendByte(8'h3C, 1, "R10"); writeRef(8'h3C);
    for (int i = 0; i < 4; i++) clockBit(1'b1, 0, "R10", smp);
    powerFail = 1'b1;
    tick(5);
    refPtr = 0;
    busStart();
    sendByte(8'hD0, 0, "R10");
    sendByte(8'h07, 0, "R10");
    powerFail = 1'b0;
    tick(5);
    busStop();
    busStart();
    sendByte(8'hD1, 1, "R10");
    readByte(8'(refMem[0]), 0, "R10");
    refPtr = 1;
    busStop();
    tick(10);

    // R4, R3: register space and write count match the model
    for (int i = 0; i < 64; i++)
      check(benchMem[i] == 8'(refMem[i]), "R4", benchMem[i], refMem[i]);
    check(seenWrites == refWrites, "R3", seenWrites, refWrites);
    check(sdaPullLow == 1'b0, "R9", sdaPullLow, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule